// File: doc/BRIEF.md
# Tick-Paced Asynchronous Serial Transceiver

This block is a full-duplex serial transceiver for frames of one start bit, eight data bits and one stop bit, with no parity. It has no baud generator of its own. A single-cycle `tick` strobe from elsewhere in the chip sets its pace. One bit period is 2^B ticks, where `B` is a parameter from 1 to 7. The resulting rate is clock / (2^B × tick spacing in clocks). For example, a tick every 163 clocks at 50 MHz with B = 4 gives roughly 19200 baud.

The transmitter takes a byte with a one-cycle `tx_valid` strobe. It then holds `tx_busy` high for exactly ten bit periods. A strobe that arrives while it is busy is dropped.

The receiver first passes the line through a two-flop synchronizer. While idle, it looks for a low level on each tick. After it sees one, it waits 1.5 bit periods plus one tick and then samples once per bit period. When the ninth sample (the stop bit) is taken, the receiver copies the assembled byte to `rx_data` and sets `rx_ready`. The flag stays set until the consumer pulses `rx_clear`.

Top module: `tick_uart`

## Requirements
- R1: A transmitted frame drives `tx_line` low (start), then data bit 0 through bit 7 (LSB first), then high (stop). The line is high whenever the transmitter is idle.
- R2: Each transmitted bit lasts 2^B ticks, counted from the load. `tx_busy` is still high after 10·2^B − 1 ticks and is low after 10·2^B ticks. `tx_busy` falls only on a tick.
- R3: A `tx_valid` strobe while `tx_busy` is low is accepted, and `tx_busy` is high in the following cycle.
- R4: A `tx_valid` strobe while `tx_busy` is high is ignored. The frame in flight keeps its bit values and its length.
- R5: `rx_line` passes through two synchronizer flops. A line that stays high never starts a reception, and `rx_ready` stays low.
- R6: The idle receiver starts on a tick that sees the synchronized line low. It takes its first sample 3·2^(B−1)+1 ticks later and each further sample 2^B ticks after the previous one. The first eight samples form `rx_data` LSB first. `rx_ready` rises on the tick of the ninth sample and never at any other time.
- R7: The stop-bit sample is not checked. A frame whose stop bit is low still sets `rx_ready` and delivers its data byte.
- R8: `rx_ready` stays set until `rx_clear` is pulsed. After the pulse it reads low in the next cycle, and `rx_data` keeps its value.
- R9: A new frame that completes while `rx_ready` is still set overwrites `rx_data`. `rx_data` changes only on the tick that completes a frame.
- R10: After reset, `tx_line` is high, `tx_busy` is low, `rx_ready` is low and `rx_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timing strobe, 2^B per bit period |
| tx_valid | input | 1 | Load strobe for `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_line | output | 1 | Serial output, idle high |
| rx_line | input | 1 | Serial input, asynchronous, idle high |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Sticky flag for a received byte |
| rx_clear | input | 1 | Clears `rx_ready` |

## Verification
The transmitter is exercised with bytes 0xA5, 0x3C and 0x5A looped back into the receiver. Sampling each bit at its midpoint separates LSB-first order from MSB-first and tells a correct bit length from one that is a tick off. The busy edge checked at ticks 159 and 160 exposes a frame that is one period short or long. A second load placed in the middle of a frame shows whether the busy guard holds the data and the length. For receiver timing, frames are bit-banged onto the line: 0x96 with a valid stop bit tests the start delay through the cycle in which `rx_ready` rises, and 0x01 with a low stop bit shows that framing is not checked. A long stretch with the line held idle, a clear pulse, and an uncleared second frame separate sticky hold, clear and overwrite behaviour.

// File: rtl/tick_uart_pkg.sv
package tick_uart_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 2;
  localparam int RX_BITS = DATA_W + 1;
  localparam int CNT_W   = 4;

  function automatic int first_sample_delay(input int blog2);
    return (3 << (blog2 - 1)) + 1;
  endfunction
endpackage

// File: rtl/tick_uart_sync.sv
module tick_uart_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= IDLE_VAL;
        else     ff <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{IDLE_VAL}};
        else     ff <= {ff[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/tick_uart_tx.sv
module tick_uart_tx
  import tick_uart_pkg::*;
#(
  parameter int B = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              line
);
  logic [B-1:0]       div_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shf_q;
  logic               accept;
  logic               period_end;

  assign accept     = load && (cnt_q == '0);
  assign period_end = tick && (cnt_q != '0) && (&div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
      shf_q <= '1;
    end else if (accept) begin
      div_q <= '0;
      cnt_q <= CNT_W'(FRAME_W);
      shf_q <= {1'b1, data, 1'b0};
    end else if (tick && (cnt_q != '0)) begin
      div_q <= div_q + 1'b1;
      if (period_end) begin
        cnt_q <= cnt_q - 1'b1;
        shf_q <= {1'b1, shf_q[FRAME_W-1:1]};
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign line = shf_q[0];
endmodule

// File: rtl/tick_uart_rx.sv
module tick_uart_rx
  import tick_uart_pkg::*;
#(
  parameter int B = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              clear,
  output logic [DATA_W-1:0] data,
  output logic              ready
);
  localparam int          DIV_W = B + 2;
  localparam logic [DIV_W-1:0] PER_V   = DIV_W'(1 << B);
  localparam logic [DIV_W-1:0] FIRST_V = DIV_W'(first_sample_delay(B));

  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shf_q;
  logic [DATA_W-1:0] data_q;
  logic              ready_q;
  logic              idle;
  logic              sample;
  logic              last;

  always_comb begin
    idle   = (cnt_q == '0);
    sample = tick && !idle && (div_q == DIV_W'(1));
    last   = sample && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
      shf_q <= '0;
    end else if (tick) begin
      if (idle) begin
        if (!line) begin
          cnt_q <= CNT_W'(RX_BITS);
          div_q <= FIRST_V;
        end
      end else if (sample) begin
        div_q <= PER_V;
        cnt_q <= cnt_q - 1'b1;
        if (!last) shf_q <= {line, shf_q[DATA_W-1:1]};
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      if (last) data_q <= shf_q;
      if (last)       ready_q <= 1'b1;
      else if (clear) ready_q <= 1'b0;
    end
  end

  assign data  = data_q;
  assign ready = ready_q;
endmodule

// File: rtl/tick_uart.sv
module tick_uart
  import tick_uart_pkg::*;
#(
  parameter int B         = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              tx_line,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_clear
);
  logic rx_sync;

  tick_uart_sync #(.STAGES(SYNC_DEPTH), .IDLE_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (rx_sync)
  );

  tick_uart_tx #(.B(B)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .load (tx_valid),
    .data (tx_data),
    .busy (tx_busy),
    .line (tx_line)
  );

  tick_uart_rx #(.B(B)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .line  (rx_sync),
    .clear (rx_clear),
    .data  (rx_data),
    .ready (rx_ready)
  );
endmodule

// File: rtl/tick_uart_chk.sv
module tick_uart_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       tx_valid,
  input logic       tx_busy,
  input logic       tx_line,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       rx_clear
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);

  p_busy_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    tx_busy && !tick |=> tx_busy);

  p_line_paced_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_line) |-> ($past(tick) || $past(tx_valid && !tx_busy)));

  p_load_taken_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_busy |=> tx_busy);

  p_ready_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> $past(tick));

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rx_ready && !rx_clear |=> rx_ready);

  p_ready_clear_r8: assert property (@(posedge clk) disable iff (rst)
    rx_ready && rx_clear && !tick |=> !rx_ready);

  p_data_update_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> (rx_ready && $past(tick)));
endmodule

bind tick_uart tick_uart_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .tx_valid (tx_valid),
  .tx_busy  (tx_busy),
  .tx_line  (tx_line),
  .rx_data  (rx_data),
  .rx_ready (rx_ready),
  .rx_clear (rx_clear)
);

// File: tb/tick_uart_tb_top.sv
`timescale 1ns/1ps
module tick_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_busy, tx_line;
  logic       loop_en = 1'b1;
  logic       drv_line = 1'b1;
  logic       rx_line;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       rx_clear = 1'b0;
  int total = 0;
  int bad = 0;

  assign rx_line = loop_en ? tx_line : drv_line;

  always #4 clk = ~clk;

  always @(negedge clk) tick <= ~tick;

  tick_uart dut_i (
    .clk(clk), .rst(rst), .tick(tick), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_line(tx_line), .rx_line(rx_line),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_clear(rx_clear)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // lets exactly n ticks be consumed by the design
  task automatic wait_ticks(input int n);
    repeat (n) begin
      while (!tick) step();
      step();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic t_reset_state();
    check("R10 tx_line", tx_line, 1);
    check("R10 tx_busy", tx_busy, 0);
    check("R10 rx_ready", rx_ready, 0);
    check("R10 rx_data", rx_data, 0);
  endtask

  task automatic t_tx_frame(input logic [7:0] d, input bit inject, input logic [7:0] d2);
    logic [9:0] f;
    f = {1'b1, d, 1'b0};
    loop_en = 1'b1;
    tx_data = d; tx_valid = 1'b1;
    step();
    tx_valid = 1'b0;
    check("R3 busy after load", tx_busy, 1);
    for (int k = 1; k <= 170; k++) begin
      wait_ticks(1);
      if (inject && k == 50) begin tx_data = d2; tx_valid = 1'b1; end
      if (inject && k == 51) tx_valid = 1'b0;
      for (int i = 0; i < 10; i++)
        if (k == 16 * i + 8)
          check(inject ? "R4 bit during ignored load" : "R1 frame bit", tx_line, f[i]);
      if (k == 159) check("R2 busy held", tx_busy, 1);
      if (k == 160) check(inject ? "R4 length kept" : "R2 busy ended", tx_busy, 0);
    end
    check("R6 loopback ready", rx_ready, 1);
    check(inject ? "R4 loopback data" : "R6 loopback data", rx_data, d);
  endtask

  task automatic t_clear(input logic [7:0] held);
    rx_clear = 1'b1;
    step();
    rx_clear = 1'b0;
    check("R8 cleared", rx_ready, 0);
    check("R8 data retained", rx_data, held);
  endtask

  task automatic t_overwrite(input logic [7:0] d);
    check("R9 ready still set", rx_ready, 1);
    t_tx_frame(d, 1'b0, 8'h00);
    check("R9 overwritten", rx_data, d);
  endtask

  task automatic t_idle_line();
    loop_en = 1'b0; drv_line = 1'b1;
    wait_ticks(300);
    check("R5 idle line no ready", rx_ready, 0);
    loop_en = 1'b1;
  endtask

  task automatic t_rx_manual(input logic [7:0] d, input logic stop);
    logic [9:0] f;
    f = {stop, d, 1'b0};
    loop_en = 1'b0;
    for (int k = 0; k < 160; k++) begin
      if (k % 16 == 0) drv_line = f[k / 16];
      wait_ticks(1);
      if (k == 152) check("R6 ready not early", rx_ready, 0);
      if (k == 157) check(stop ? "R6 ready on time" : "R7 ready despite low stop", rx_ready, 1);
    end
    check(stop ? "R6 manual data" : "R7 data despite low stop", rx_data, d);
    drv_line = 1'b1;
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_tx_frame(8'hA5, 1'b0, 8'h00);
    t_clear(8'hA5);
    t_tx_frame(8'h3C, 1'b1, 8'hFF);
    t_overwrite(8'h5A);
    t_clear(8'h5A);
    t_idle_line();
    t_rx_manual(8'h96, 1'b1);
    t_clear(8'h96);
    t_rx_manual(8'h01, 1'b0);
    do_reset();
    t_reset_state();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule